// File: doc/BRIEF.md
# Vector predicate mask lookup

This block turns one architectural register operand into an element-enable mask and a zeroing flag for the instruction that uses it. It keeps two small predicate configuration tables, one for integer operands and one for floating-point operands. Each table has one entry per architectural register number. An entry holds an enable bit, an invert bit, a zeroing bit and the number of an integer register that holds the mask bits.

For a lookup, the operand's register number and class pick an entry. The register-redirection enable bit for the same operand also comes in from outside. When both the redirection and the predicate entry are enabled, the block puts the entry's source register number on a read port into the integer register file. The returned value becomes the mask, complemented if the invert bit is set, and the zeroing bit passes through. In every other case the mask is all ones, so every element is enabled, and zeroing is off.

The mask has one bit per element, so its width, XLEN, is the longest vector the block can predicate. The lookup path is combinational. Table writes are registered.

Top module: `pred_mask_lookup`

## Requirements
- R1: The integer table (cfg_fp=0, lk_fp=0) and the floating-point table (cfg_fp=1, lk_fp=1) are separate. A write to one never changes what a lookup in the other returns.
- R2: When redir_active is 0, mask is all ones (XLEN bits of 1) and zeroing is 0, whatever the table holds.
- R3: When redir_active is 1 and the selected entry's enable bit is 0, mask is all ones and zeroing is 0.
- R4: rf_raddr always carries the selected entry's source register number. When redir_active is 1, the entry is enabled and its invert bit is 0, mask equals rf_rdata.
- R5: When redir_active is 1, the entry is enabled and its invert bit is 1, mask equals the bitwise complement of rf_rdata.
- R6: When redir_active is 1 and the entry is enabled, zeroing equals the entry's zero bit.
- R7: A write with cfg_we=1 updates the entry at (cfg_fp, cfg_idx) on the rising clock edge. The new contents are seen by lookups from the next cycle onward, and the same cycle still sees the old contents.
- R8: While rst_n is 0, every entry of both tables is cleared to disabled with a source register of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_fp | input | 1 | Table select for the write: 0 selects integer, 1 selects floating point |
| cfg_idx | input | IDXW | Entry number to write |
| cfg_en | input | 1 | Enable bit to store |
| cfg_inv | input | 1 | Invert bit to store |
| cfg_zero | input | 1 | Zeroing bit to store |
| cfg_src | input | SRCW | Source integer register number to store |
| lk_fp | input | 1 | Operand class for the lookup: 0 is integer, 1 is floating point |
| lk_reg | input | IDXW | Operand's architectural register number |
| redir_active | input | 1 | Redirection enable bit for the operand |
| rf_raddr | output | SRCW | Integer register file read address |
| rf_rdata | input | XLEN | Integer register file read data |
| mask | output | XLEN | Element enable mask |
| zeroing | output | 1 | Zeroing indication |

## Verification
The bench builds the block with XLEN=32, 32 entries per table and 6-bit source numbers. The narrower mask keeps the expected values short to state, and the 6-bit source field still reaches registers above 31. A register file model returns 0 for register 0 and a scrambled nonzero word for every other register. This puts both an all-zero mask and its all-ones complement within reach. Random writes and lookups to a small set of entries often hit the same entry in both tables and read just-written entries on the following cycle.

// File: rtl/pred_mask_lookup.sv
module pred_mask_lookup #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int SRCW = 6,
  localparam int IDXW = $clog2(NREG),
  localparam int EW = 3 + SRCW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_fp,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic            cfg_en,
  input  logic            cfg_inv,
  input  logic            cfg_zero,
  input  logic [SRCW-1:0] cfg_src,
  input  logic            lk_fp,
  input  logic [IDXW-1:0] lk_reg,
  input  logic            redir_active,
  output logic [SRCW-1:0] rf_raddr,
  input  logic [XLEN-1:0] rf_rdata,
  output logic [XLEN-1:0] mask,
  output logic            zeroing
);

  logic [EW-1:0] tab_q [2][NREG];
  logic [EW-1:0] ent;
  logic          ent_en, ent_inv, ent_zero, pred_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < NREG; i++)
          tab_q[t][i] <= '0;
    end else if (cfg_we) begin
      tab_q[cfg_fp][cfg_idx] <= {cfg_en, cfg_inv, cfg_zero, cfg_src};
    end
  end

  assign ent      = tab_q[lk_fp][lk_reg];
  assign ent_en   = ent[EW-1];
  assign ent_inv  = ent[EW-2];
  assign ent_zero = ent[EW-3];
  assign rf_raddr = ent[SRCW-1:0];
  assign pred_on  = redir_active && ent_en;

  assign mask    = !pred_on ? '1 : (ent_inv ? ~rf_rdata : rf_rdata);
  assign zeroing = pred_on && ent_zero;

  AST_NO_REDIR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_active |-> (mask == '1 && !zeroing)); // R2
  AST_ZERO_NEEDS_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    zeroing |-> redir_active); // R6
  AST_MASK_FROM_RF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask != '1) |-> (mask == rf_rdata || mask == ~rf_rdata)); // R4
  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && $past(rst_n) && lk_fp == $past(cfg_fp) && lk_reg == $past(cfg_idx))
      |-> rf_raddr == $past(cfg_src)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    ($past(!rst_n) && rst_n && redir_active) |-> (mask == '1 && rf_raddr == '0)); // R8

endmodule

// File: tb/tb_pred_mask_lookup.sv
module tb_pred_mask_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int XL = 32;
  localparam int NR = 32;
  localparam int SW = 6;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_fp = 0, cfg_en = 0, cfg_inv = 0, cfg_zero = 0;
  logic [4:0] cfg_idx = 0, lk_reg = 0;
  logic [SW-1:0] cfg_src = 0;
  logic lk_fp = 0, redir_active = 0;
  logic [SW-1:0] rf_raddr;
  logic [XL-1:0] rf_rdata, mask;
  logic zeroing;

  int total = 0, bad = 0;
  logic [8:0] m_tab [2][NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [XL-1:0] rf_val(logic [SW-1:0] a);
    logic [XL-1:0] v;
    v = (a == 0) ? '0 : ((XL'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F);
    return v;
  endfunction

  assign rf_rdata = rf_val(rf_raddr);

  pred_mask_lookup #(.XLEN(XL), .NREG(NR), .SRCW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fp(cfg_fp), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_inv(cfg_inv), .cfg_zero(cfg_zero), .cfg_src(cfg_src),
    .lk_fp(lk_fp), .lk_reg(lk_reg), .redir_active(redir_active),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .mask(mask), .zeroing(zeroing));

  task automatic chk(string req, logic [XL-1:0] act, logic [XL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_lookup(string tag);
    logic [8:0] e;
    logic [XL-1:0] em;
    logic ez;
    string req;
    e = m_tab[lk_fp][lk_reg];
    chk({tag, " R4 raddr"}, XL'(rf_raddr), XL'(e[5:0]));
    if (!redir_active) begin em = '1; ez = 0; req = "R2"; end
    else if (!e[8]) begin em = '1; ez = 0; req = "R3"; end
    else begin
      em = e[7] ? ~rf_val(e[5:0]) : rf_val(e[5:0]);
      ez = e[6];
      req = e[7] ? "R5" : "R4";
    end
    chk({tag, " ", req, " mask"}, mask, em);
    chk({tag, " R6 zeroing"}, XL'(zeroing), XL'(ez));
  endtask

  task automatic cycle(logic we, logic wfp, logic [4:0] widx, logic [8:0] wval,
                       logic lfp, logic [4:0] lreg, logic redir, string tag);
    @(negedge clk);
    cfg_we = we; cfg_fp = wfp; cfg_idx = widx;
    {cfg_en, cfg_inv, cfg_zero} = wval[8:6]; cfg_src = wval[5:0];
    lk_fp = lfp; lk_reg = lreg; redir_active = redir;
    #1 check_lookup(tag);
    @(posedge clk);
    if (we) m_tab[wfp][widx] = wval;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    for (int t = 0; t < 2; t++) for (int i = 0; i < NR; i++) m_tab[t][i] = '0;
    // Put junk in a table entry while reset is held; reset must clear it (R8).
    @(negedge clk); cfg_we = 1; cfg_idx = 3; cfg_en = 1; cfg_src = 9;
    repeat (3) @(negedge clk);
    cfg_we = 0; rst_n = 1;
    cycle(0, 0, 0, 0, 0, 3, 1, "R8 reset int");
    cycle(0, 0, 0, 0, 1, 3, 1, "R8 reset fp");
    // Directed corner cases.
    cycle(1, 0, 7, {3'b101, 6'd0}, 0, 7, 1, "R7 old value");
    cycle(0, 0, 0, 0, 0, 7, 1, "R7 new value");
    cycle(0, 0, 0, 0, 1, 7, 1, "R1 fp untouched");
    cycle(0, 0, 0, 0, 0, 7, 0, "R2 redir off");
    cycle(1, 0, 7, {3'b110, 6'd0}, 0, 7, 1, "R5 pre");
    cycle(0, 0, 0, 0, 0, 7, 1, "R5 invert zero reg");
    cycle(1, 1, 7, {3'b011, 6'd40}, 1, 7, 1, "R3 pre");
    cycle(0, 0, 0, 0, 1, 7, 1, "R3 disabled entry");
    cycle(1, 1, 7, {3'b111, 6'd63}, 0, 7, 1, "R1 pre");
    cycle(0, 0, 0, 0, 1, 7, 1, "R6 fp high src");
    cycle(0, 0, 0, 0, 0, 7, 1, "R1 int kept");
    // Random mix over a small set of entries so collisions are frequent.
    for (int n = 0; n < 3000; n++) begin
      cycle($urandom_range(0, 2) == 0, $urandom_range(0, 1), 5'($urandom_range(0, 5)),
            9'($urandom), $urandom_range(0, 1), 5'($urandom_range(0, 5)),
            $urandom_range(0, 3) != 0, "random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule